// File: doc/BRIEF.md
# Train-Synchronous Power-Pulse Readout Sequencer

This block sits on the detector side of a data acquisition chain, between the link that carries decoded fast commands from an aggregator and a chain of front-end chips. The chips all share one readout bus. A train-start command opens an acquisition window, and every chip is powered for the whole of it. A train-stop command closes the window and switches every chip off. The sequencer then walks the chain one chip at a time. For each chip it switches on that chip's supply, waits a programmable settling time, and sends a header. It then starts that chip's readout and forwards the chip's bytes upstream as they arrive. It closes the frame with the byte count and a status trailer, and switches the chip off again before it moves to the next chip.

A chip can stall, so each readout has a programmable inactivity timeout. When the timeout expires, the sequencer ends that chip's frame with an error trailer and carries on with the next chip. A train-start that arrives while the readout is still running is reported on an error pulse and does not disturb the readout. Keeping the chips powered only during the train and during their own readout slot holds the average supply duty cycle low.

Top module: `pp_readout_seq`

## Requirements
- R1: A command with code 2'b01 (train start), received while idle, raises `acq_active` and drives every bit of `chip_pwr_en` high. The frame train number (8 bits, starting at 1 after reset) then increments once. A second start during the same acquisition has no effect.
- R2: A command with code 2'b10 (train stop) ends an acquisition. Codes 2'b00 and 2'b11, and a stop received while idle, leave `acq_active`, `chip_pwr_en` and the output stream unchanged.
- R3: After a stop, chips 0 to K-1 are read out in ascending order, one `chip_ro_start` pulse each, where K is the configured chip count. Outside acquisition at most one `chip_pwr_en` bit is high at any time. All enables are low once the last frame has been sent. K = 0 gives no readout.
- R4: `chip_ro_start[i]` pulses for one cycle exactly `cfg_settle`+4 cycles after `chip_pwr_en[i]` rises, and only while that chip is powered.
- R5: Each chip's frame is, in order: 0xA5 (flagged by `out_sof`), the train number, the chip index, the payload, the payload length as two bytes (high byte first), then a trailer flagged by `out_eof`. The trailer is 0x5A for normal completion and 0x5B for a timeout.
- R6: Every byte presented with `chip_dvalid` during a chip's readout is forwarded in order. A byte that arrives in the same cycle as `chip_done` is included.
- R7: If `cfg_timeout` cycles pass with neither data nor done from the chip being read, its frame is closed with trailer 0x5B and the next chip is handled.
- R8: A train start received during readout pulses `err_overlap` once, starts no acquisition and does not change the frames being produced.
- R9: During and after reset, `acq_active`, `chip_pwr_en`, `chip_ro_start`, `out_valid` and `err_overlap` are all low.
- R10: `cfg_nchips` is sampled at the train stop. Values above the number of chip slots are clamped to that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | A decoded fast command is present |
| cmd_code | input | 2 | Command code: 01 train start, 10 train stop |
| cfg_nchips | input | $clog2(NCHIP+1) | Number of chips to read after each train |
| cfg_settle | input | SETTLE_W | Settling wait after power-up, in cycles |
| cfg_timeout | input | TMO_W | Inactivity limit during a chip readout, in cycles |
| chip_dvalid | input | 1 | Shared readout bus carries a byte |
| chip_data | input | 8 | Shared readout bus byte |
| chip_done | input | 1 | The chip being read has finished |
| acq_active | output | 1 | Acquisition window open |
| chip_pwr_en | output | NCHIP | Per-chip supply enable |
| chip_ro_start | output | NCHIP | Per-chip one-cycle readout start |
| out_valid | output | 1 | Framed output byte valid |
| out_data | output | 8 | Framed output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| err_overlap | output | 1 | Train start arrived during readout |

## Verification
The hardest situation to reach from the ports is a train start that lands in the middle of a readout. It has to be timed against the chip-by-chip walk without being mistaken for a fresh acquisition. The bench waits until it sees the second chip's supply rise after a stop, injects the start at that point, and then still demands bit-exact frames for the whole train. Timeouts are exercised by a bench chip model that goes silent after at most two bytes, with the stalled chip's index swept across the chain. The sweep runs over every chip-count value, including zero and values above the slot count, and over two settling times.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;

  localparam logic [1:0] CMD_TRAIN_START = 2'b01;
  localparam logic [1:0] CMD_TRAIN_STOP  = 2'b10;

  localparam logic [BYTE_W-1:0] FRAME_SYNC  = 8'hA5;
  localparam logic [BYTE_W-1:0] TRAILER_OK  = 8'h5A;
  localparam logic [BYTE_W-1:0] TRAILER_TMO = 8'h5B;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SLEEP,
    ST_PWRUP,
    ST_HDR,
    ST_COLLECT,
    ST_TAIL,
    ST_PWRDN
  } seq_st_e;

  typedef struct packed {
    logic              valid;
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } emit_t;
endpackage

// File: rtl/pp_cmd_decode.sv
module pp_cmd_decode
  import pp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  output logic       start_p,
  output logic       stop_p
);
  logic start_d, stop_d;

  always_comb begin
    start_d = cmd_valid && (cmd_code == CMD_TRAIN_START);
    stop_d  = cmd_valid && (cmd_code == CMD_TRAIN_STOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      start_p <= start_d;
      stop_p  <= stop_d;
    end
  end

  // R2: one decoded command never yields both pulses
  p_cmd_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p));
endmodule

// File: rtl/pp_seq_ctrl.sv
module pp_seq_ctrl
  import pp_seq_pkg::*;
#(
  parameter int NCHIP    = 4,
  parameter int SETTLE_W = 8,
  parameter int TMO_W    = 12,
  localparam int CNT_W   = $clog2(NCHIP + 1),
  localparam int CIDX_W  = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_p,
  input  logic                stop_p,
  input  logic [CNT_W-1:0]    cfg_nchips,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [TMO_W-1:0]    cfg_timeout,
  input  logic                chip_dvalid,
  input  logic [BYTE_W-1:0]   chip_data,
  input  logic                chip_done,
  output logic                acq_active,
  output logic [NCHIP-1:0]    pwr_en,
  output logic [NCHIP-1:0]    ro_start,
  output logic                err_overlap,
  output emit_t               emit
);
  localparam int CW = (SETTLE_W > TMO_W) ? SETTLE_W : TMO_W;
  localparam logic [CNT_W-1:0] NCHIP_C = CNT_W'(NCHIP);

  seq_st_e             st_q, st_d;
  logic [CIDX_W-1:0]   chip_q, chip_d;
  logic [CNT_W-1:0]    last_q, last_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [7:0]          train_q, train_d;
  logic                tmo_q, tmo_d;
  logic [NCHIP-1:0]    pwr_q, pwr_d;
  logic [NCHIP-1:0]    ro_q, ro_d;
  logic                ovl_q, ovl_d;
  logic                tmo_hit;
  logic                busy;

  assign tmo_hit = (cnt_q >= CW'(cfg_timeout));
  assign busy    = (st_q != ST_IDLE) && (st_q != ST_ACQ);

  // next-state process
  always_comb begin
    st_d    = st_q;
    chip_d  = chip_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    train_d = train_q;
    tmo_d   = tmo_q;
    ro_d    = '0;
    ovl_d   = start_p && busy;
    emit    = '0;
    case (st_q)
      ST_IDLE: begin
        if (start_p) begin
          st_d    = ST_ACQ;
          train_d = train_q + 8'd1;
        end
      end
      ST_ACQ: begin
        if (stop_p) begin
          st_d   = ST_SLEEP;
          last_d = (cfg_nchips > NCHIP_C) ? NCHIP_C : cfg_nchips;
        end
      end
      ST_SLEEP: begin
        chip_d = '0;
        cnt_d  = '0;
        st_d   = (last_q == '0) ? ST_IDLE : ST_PWRUP;
      end
      ST_PWRUP: begin
        if (cnt_q == CW'(cfg_settle)) begin
          st_d  = ST_HDR;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HDR: begin
        emit.valid = 1'b1;
        case (cnt_q[1:0])
          2'd0:    begin emit.data = FRAME_SYNC; emit.sof = 1'b1; end
          2'd1:    emit.data = train_q;
          default: emit.data = BYTE_W'(chip_q);
        endcase
        if (cnt_q[1:0] == 2'd2) begin
          st_d         = ST_COLLECT;
          cnt_d        = '0;
          len_d        = '0;
          tmo_d        = 1'b0;
          ro_d[chip_q] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_COLLECT: begin
        if (chip_dvalid) begin
          emit.valid = 1'b1;
          emit.data  = chip_data;
          len_d      = len_q + 1'b1;
        end
        if (chip_done) begin
          st_d  = ST_TAIL;
          cnt_d = '0;
        end else if (chip_dvalid) begin
          cnt_d = '0;
        end else if (tmo_hit) begin
          st_d  = ST_TAIL;
          cnt_d = '0;
          tmo_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TAIL: begin
        emit.valid = 1'b1;
        case (cnt_q[1:0])
          2'd0:    emit.data = len_q[15:8];
          2'd1:    emit.data = len_q[7:0];
          default: begin
            emit.data = tmo_q ? TRAILER_TMO : TRAILER_OK;
            emit.eof  = 1'b1;
          end
        endcase
        if (cnt_q[1:0] == 2'd2) begin
          st_d  = ST_PWRDN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PWRDN: begin
        if (CNT_W'(chip_q) + 1'b1 == last_q) begin
          st_d = ST_IDLE;
        end else begin
          chip_d = chip_q + 1'b1;
          cnt_d  = '0;
          st_d   = ST_PWRUP;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    pwr_d = '0;
    case (st_d)
      ST_ACQ:                               pwr_d = '1;
      ST_PWRUP, ST_HDR, ST_COLLECT, ST_TAIL: pwr_d[chip_d] = 1'b1;
      default:                              pwr_d = '0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chip_q  <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      train_q <= '0;
      tmo_q   <= 1'b0;
      pwr_q   <= '0;
      ro_q    <= '0;
      ovl_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pwr_q <= pwr_d;
      ro_q  <= ro_d;
      ovl_q <= ovl_d;
      if (st_q == ST_ACQ)                        last_q  <= last_d;
      if (st_q == ST_IDLE)                       train_q <= train_d;
      if (st_q == ST_SLEEP || st_q == ST_PWRDN)  chip_q  <= chip_d;
      if (st_q == ST_HDR || st_q == ST_COLLECT)  len_q   <= len_d;
      if (st_q == ST_HDR || st_q == ST_COLLECT)  tmo_q   <= tmo_d;
    end
  end

  assign acq_active  = (st_q == ST_ACQ);
  assign pwr_en      = pwr_q;
  assign ro_start    = ro_q;
  assign err_overlap = ovl_q;

  // R1: the open window powers every chip
  p_acq_allpwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acq_active |-> (&pwr_en));
  // R3: a single supply at a time outside the window
  p_single_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_active |-> ($countones(pwr_en) <= 1));
  // R3: at most one readout start per cycle
  p_ro_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ro_start));
  // R4: readout only starts on a powered chip
  p_ro_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ro_start) |-> ((ro_start & ~pwr_en) == '0));
  // R7: an expired inactivity window closes the frame flagged as error
  p_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT && !chip_dvalid && !chip_done && tmo_hit)
      |=> (st_q == ST_TAIL && tmo_q));
  // R8: an overlap error never coincides with an open window
  p_ovl_noacq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overlap |-> !acq_active);
endmodule

// File: rtl/pp_framer.sv
module pp_framer
  import pp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  emit_t             emit,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);
  emit_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q.valid <= emit.valid;
      if (emit.valid) begin
        q.sof  <= emit.sof;
        q.eof  <= emit.eof;
        q.data <= emit.data;
      end
    end
  end

  assign out_valid = q.valid;
  assign out_data  = q.data;
  assign out_sof   = q.valid && q.sof;
  assign out_eof   = q.valid && q.eof;

  // R5: frame starts carry the sync byte
  p_sof_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_data == FRAME_SYNC));
  // R5: frame ends carry a trailer code
  p_eof_trailer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (out_data == TRAILER_OK || out_data == TRAILER_TMO));
endmodule

// File: rtl/pp_readout_seq.sv
module pp_readout_seq
  import pp_seq_pkg::*;
#(
  parameter int NCHIP    = 4,
  parameter int SETTLE_W = 8,
  parameter int TMO_W    = 12,
  localparam int CNT_W   = $clog2(NCHIP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  input  logic [CNT_W-1:0]    cfg_nchips,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [TMO_W-1:0]    cfg_timeout,
  input  logic                chip_dvalid,
  input  logic [7:0]          chip_data,
  input  logic                chip_done,
  output logic                acq_active,
  output logic [NCHIP-1:0]    chip_pwr_en,
  output logic [NCHIP-1:0]    chip_ro_start,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                out_sof,
  output logic                out_eof,
  output logic                err_overlap
);
  logic [1:0] rst_sync;
  logic       rst_n_i;
  logic       start_p, stop_p;
  emit_t      emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  pp_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .start_p(start_p), .stop_p(stop_p)
  );

  pp_seq_ctrl #(.NCHIP(NCHIP), .SETTLE_W(SETTLE_W), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .start_p(start_p), .stop_p(stop_p),
    .cfg_nchips(cfg_nchips), .cfg_settle(cfg_settle), .cfg_timeout(cfg_timeout),
    .chip_dvalid(chip_dvalid), .chip_data(chip_data), .chip_done(chip_done),
    .acq_active(acq_active), .pwr_en(chip_pwr_en), .ro_start(chip_ro_start),
    .err_overlap(err_overlap), .emit(emit)
  );

  pp_framer u_frm (
    .clk(clk), .rst_n(rst_n_i), .emit(emit),
    .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );
endmodule

// File: tb/pp_readout_seq_tb.sv
module pp_readout_seq_tb;
  localparam int NCHIP = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_code;
  logic [2:0] cfg_nchips;
  logic [7:0] cfg_settle;
  logic [11:0] cfg_timeout;
  logic       chip_dvalid, chip_done;
  logic [7:0] chip_data;
  logic       acq_active, out_valid, out_sof, out_eof, err_overlap;
  logic [NCHIP-1:0] chip_pwr_en, chip_ro_start;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_train = 0;
  int ovl_cnt = 0;
  int len_tab [NCHIP];
  int stall_chip = -1;
  int gap = 2;
  int rise_cyc [NCHIP];
  logic [NCHIP-1:0] prev_pwr = '0;
  bit multi_pwr = 0;
  logic [9:0] got_q [$];
  int ro_q [$];

  always #5 clk = ~clk;

  pp_readout_seq #(.NCHIP(NCHIP), .SETTLE_W(8), .TMO_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cfg_nchips(cfg_nchips), .cfg_settle(cfg_settle), .cfg_timeout(cfg_timeout),
    .chip_dvalid(chip_dvalid), .chip_data(chip_data), .chip_done(chip_done),
    .acq_active(acq_active), .chip_pwr_en(chip_pwr_en), .chip_ro_start(chip_ro_start),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .err_overlap(err_overlap)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int tr, input int id, input int k);
    return 8'((tr * 37 + id * 11 + k) & 255);
  endfunction

  // monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (out_valid) got_q.push_back({out_eof, out_sof, out_data});
      if (err_overlap) ovl_cnt++;
      if (!acq_active && $countones(chip_pwr_en) > 1) multi_pwr = 1;
      for (int i = 0; i < NCHIP; i++) begin
        if (chip_pwr_en[i] && !prev_pwr[i]) rise_cyc[i] = cyc;
        if (chip_ro_start[i]) begin
          ro_q.push_back(i);
          check(chip_pwr_en[i] && (cyc - rise_cyc[i] == int'(cfg_settle) + 4),
                "R4", "settle cycles", cyc - rise_cyc[i], int'(cfg_settle) + 4);
        end
      end
      prev_pwr = chip_pwr_en;
      if (cyc > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // front-end chip chain model
  initial begin
    int id, sendn;
    bool_dummy: begin end
    chip_dvalid = 1'b0; chip_done = 1'b0; chip_data = '0;
    forever begin
      @(negedge clk);
      if (|chip_ro_start) begin
        id = 0;
        for (int i = 0; i < NCHIP; i++) if (chip_ro_start[i]) id = i;
        sendn = (id == stall_chip) ? ((len_tab[id] < 2) ? len_tab[id] : 2) : len_tab[id];
        repeat (gap) @(negedge clk);
        for (int k = 0; k < sendn; k++) begin
          chip_dvalid = 1'b1;
          chip_data   = pat(cur_train, id, k);
          chip_done   = (id != stall_chip) && (k == sendn - 1) && (id % 2 == 1);
          @(negedge clk);
        end
        chip_dvalid = 1'b0;
        chip_done   = 1'b0;
        if (id != stall_chip && !((id % 2 == 1) && sendn > 0)) begin
          chip_done = 1'b1;
          @(negedge clk);
          chip_done = 1'b0;
        end
      end
    end
  end

  task automatic send_cmd(input logic [1:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 2'b00;
  endtask

  function automatic int eof_count();
    int n = 0;
    foreach (got_q[i]) if (got_q[i][9]) n++;
    return n;
  endfunction

  task automatic run_train(input int n, input int settle, input int stall,
                           input bit dbl_start, input bit ovl);
    int k_exp, guard, o0;
    logic [9:0] exp_q [$];
    int mism;
    k_exp = (n > NCHIP) ? NCHIP : n;
    cfg_nchips = 3'(n);
    cfg_settle = 8'(settle);
    got_q.delete();
    ro_q.delete();
    multi_pwr = 0;
    stall_chip = stall;
    for (int i = 0; i < NCHIP; i++) len_tab[i] = (i + n + settle) % 5;
    cur_train++;
    send_cmd(2'b01);
    if (dbl_start) send_cmd(2'b01);
    repeat (4) @(negedge clk);
    check(acq_active == 1'b1, "R1", "acq_active in train", acq_active, 1);
    check(chip_pwr_en == '1, "R1", "all chips powered", chip_pwr_en, 15);
    send_cmd(2'b10);
    if (ovl) begin
      guard = 0;
      while (!(chip_pwr_en[1] && !acq_active) && guard < 5000) begin
        @(negedge clk); guard++;
      end
      o0 = ovl_cnt;
      send_cmd(2'b01);
      repeat (4) @(negedge clk);
      check(ovl_cnt == o0 + 1, "R8", "overlap error pulses", ovl_cnt - o0, 1);
      check(acq_active == 1'b0, "R8", "no acquisition on overlap", acq_active, 0);
    end
    guard = 0;
    while (eof_count() < k_exp && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat ((k_exp == 0) ? 30 : 5) @(negedge clk);
    // expected stream (R5, R6, R7)
    for (int i = 0; i < k_exp; i++) begin
      int pl;
      pl = (i == stall) ? ((len_tab[i] < 2) ? len_tab[i] : 2) : len_tab[i];
      exp_q.push_back({2'b01, 8'hA5});
      exp_q.push_back({2'b00, 8'(cur_train & 255)});
      exp_q.push_back({2'b00, 8'(i)});
      for (int k = 0; k < pl; k++) exp_q.push_back({2'b00, pat(cur_train, i, k)});
      exp_q.push_back({2'b00, 8'(pl >> 8)});
      exp_q.push_back({2'b00, 8'(pl & 255)});
      exp_q.push_back({2'b10, (i == stall) ? 8'h5B : 8'h5A});
    end
    check(got_q.size() == exp_q.size(), "R5", "frame byte count",
          got_q.size(), exp_q.size());
    mism = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (mism < 0 && got_q[i] !== exp_q[i]) mism = i;
    if (mism >= 0)
      check(0, (stall >= 0 && stall < k_exp) ? "R7" : "R6", "stream byte",
            got_q[mism], exp_q[mism]);
    else
      check(1, "R6", "stream content", 0, 0);
    check(ro_q.size() == k_exp, "R3", "readout starts", ro_q.size(), k_exp);
    mism = 0;
    foreach (ro_q[i]) if (ro_q[i] != i) mism = 1;
    check(mism == 0, (n > NCHIP) ? "R10" : "R3", "readout order", mism, 0);
    check(!multi_pwr, "R3", "single chip powered", multi_pwr, 0);
    check(chip_pwr_en == '0 && !acq_active, "R3", "all off after readout",
          chip_pwr_en, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_code = 2'b00;
    cfg_nchips = 3'd4; cfg_settle = 8'd0; cfg_timeout = 12'd20;
    repeat (3) @(negedge clk);
    check(!acq_active && chip_pwr_en == '0 && chip_ro_start == '0 && !out_valid
          && !err_overlap, "R9", "outputs in reset", chip_pwr_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!acq_active && chip_pwr_en == '0 && !out_valid, "R9",
          "outputs after reset", chip_pwr_en, 0);

    // R2: ignored codes and stray stop
    got_q.delete();
    send_cmd(2'b11);
    send_cmd(2'b00);
    send_cmd(2'b10);
    repeat (20) @(negedge clk);
    check(!acq_active && chip_pwr_en == '0, "R2", "ignored commands", acq_active, 0);
    check(got_q.size() == 0, "R2", "no output on ignored commands", got_q.size(), 0);

    // sweep chip count, settle time and stalled chip
    for (int n = 0; n < 8; n++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 2; st++)
          run_train(n, s * 3, (st == 0) ? -1 : (n % NCHIP), (n % 2) == 1, 1'b0);

    // R8: start during readout
    run_train(3, 1, -1, 1'b0, 1'b1);
    run_train(4, 2, 3, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule